// File: doc/BRIEF.md
# Modem Serial Transmit Front End

This block sits between a host and the data input of a modem modulator. A control byte picks one of three synchronous modes, four asynchronous character formats, or power down. In the synchronous modes a serial bit from the host is passed through one bit per transmit clock edge. That clock comes from an internal rate strobe, from an external clock pin, or from the receive clock. In the asynchronous modes a parallel character arrives over a valid/ready handshake. The block frames it with a start bit, data, optional parity and stop bits, and sends one bit per rate strobe.

All logic runs on one system clock. The external and receive clocks are treated as data: each passes through a synchronizer and a rising-edge detector. The serial data bit goes through a pipeline of the same depth, so it stays aligned with the clock edge that sampled it. A transmit-enable bit gates the output to the idle level. A new mode is adopted only while no character is in flight.

Top module: `mdm_tx_front`

## Requirements
- R1: With the enable bit ctrl_i[1] at 0, txd_o stays 1, ready_o stays 0 and active_o stays 0 in every mode, even while sync_bit_i is 0.
- R2: Mode field ctrl_i[5:2] = 0000 (power down) or any code 1000 to 1111 holds txd_o at 1 and ready_o and active_o at 0. A character offered with valid_i in that state is never transmitted.
- R3: In mode 0001, each cycle with rate_stb_i high samples sync_bit_i, and txd_o shows that bit from the next cycle. active_o is 1.
- R4: In mode 0010, a rising edge of ext_clk_i samples sync_bit_i, and txd_o shows it within SYNC_STAGES+2 cycles. Edges of rx_clk_i have no effect on txd_o.
- R5: In mode 0011, a rising edge of rx_clk_i samples sync_bit_i in the same way. Edges of ext_clk_i have no effect.
- R6: Modes 0100, 0101 and 0110 send a 0 start bit, then 6, 7 or 8 data bits LSB first, then one stop bit of 1. Each bit lasts one strobe period, and the start bit begins at the first strobe after acceptance.
- R7: Mode 0111 sends 8 data bits. When par_en_i is 1, a parity bit follows them: even parity when par_odd_i is 0 (data plus parity hold an even number of ones), odd parity when par_odd_i is 1. Then come 1 stop bit, or 2 when two_stop_i is 1.
- R8: ready_o is 1 only when enabled, in an asynchronous mode, and idle. A character is taken on a cycle with valid_i and ready_o both high. ready_o drops at once and returns on the strobe that ends the last stop bit.
- R9: A mode change made while a character is in flight does not alter that character's length or bits. The new mode applies to the next character.
- R10: After reset, txd_o is 1 and ready_o and active_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Control byte: bit 1 is transmit enable, bits 5:2 are the mode |
| par_en_i | input | 1 | Parity enable for mode 0111 |
| par_odd_i | input | 1 | Odd parity when 1, even parity when 0 |
| two_stop_i | input | 1 | Two stop bits in mode 0111 |
| rate_stb_i | input | 1 | One-cycle bit-rate strobe from the internal divider |
| ext_clk_i | input | 1 | External transmit clock |
| rx_clk_i | input | 1 | Receive clock, used as the slave transmit clock |
| data_i | input | DATA_W | Parallel character |
| valid_i | input | 1 | Character valid |
| ready_o | output | 1 | Character may be accepted |
| sync_bit_i | input | 1 | Serial data for the synchronous modes |
| txd_o | output | 1 | Serial stream to the modulator |
| active_o | output | 1 | Transmitter is sending |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2, and fires the rate strobe every eight clocks. With these values every frame length from 8 to 12 bits can be reached, along with both parity senses and the two-stop case. A two-stage synchronizer lets the bench check the external and slaved clock paths a fixed five cycles after each edge. Random characters in random asynchronous formats are mixed with directed cases: a mode switch in mid-frame, offers made during power down, and clock edges on the source that is not selected.

// File: rtl/mdm_tx_pkg.sv
package mdm_tx_pkg;
  localparam logic [3:0] MD_PDN  = 4'd0;
  localparam logic [3:0] MD_SINT = 4'd1;
  localparam logic [3:0] MD_SEXT = 4'd2;
  localparam logic [3:0] MD_SSLV = 4'd3;
  localparam logic [3:0] MD_A6   = 4'd4;
  localparam logic [3:0] MD_A7   = 4'd5;
  localparam logic [3:0] MD_A8   = 4'd6;
  localparam logic [3:0] MD_AX   = 4'd7;

  function automatic logic is_sync(logic [3:0] m);
    return (m == MD_SINT) || (m == MD_SEXT) || (m == MD_SSLV);
  endfunction

  function automatic logic is_async(logic [3:0] m);
    return (m == MD_A6) || (m == MD_A7) || (m == MD_A8) || (m == MD_AX);
  endfunction
endpackage

// File: rtl/mdm_tx_clk_sel.sv
module mdm_tx_clk_sel
  import mdm_tx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_i,
  input  logic       rate_stb_i,
  input  logic       ext_clk_i,
  input  logic       rx_clk_i,
  input  logic       sync_bit_i,
  output logic       tick_o,
  output logic       bit_o
);
  // one extra stage on the clock chains for edge detection
  logic [STAGES:0]   ext_s, rx_s;
  logic [STAGES-1:0] dat_s;
  logic              ext_edge, rx_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_s <= '0;
      rx_s  <= '0;
      dat_s <= '1;
    end else begin
      ext_s <= {ext_s[STAGES-1:0], ext_clk_i};
      rx_s  <= {rx_s[STAGES-1:0], rx_clk_i};
      dat_s <= {dat_s[STAGES-2:0], sync_bit_i};
    end
  end

  assign ext_edge = ext_s[STAGES-1] & ~ext_s[STAGES];
  assign rx_edge  = rx_s[STAGES-1] & ~rx_s[STAGES];

  always_comb begin
    unique case (mode_i)
      MD_SEXT: begin tick_o = ext_edge;   bit_o = dat_s[STAGES-1]; end
      MD_SSLV: begin tick_o = rx_edge;    bit_o = dat_s[STAGES-1]; end
      default: begin tick_o = rate_stb_i; bit_o = sync_bit_i;      end
    endcase
  end

  // R4
  ext_edge_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_edge |=> !ext_edge);
  // R5
  rx_edge_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_edge |=> !rx_edge);
endmodule

// File: rtl/mdm_tx_framer.sv
module mdm_tx_framer
  import mdm_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [3:0]        mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              line_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame, sh_q;
  logic [CNT_W-1:0]   len, cnt_q;
  logic               ext_fmt;
  int                 dbits;

  assign ext_fmt = (mode_i == MD_AX);

  always_comb begin
    unique case (mode_i)
      MD_A6:   dbits = DATA_W - 2;
      MD_A7:   dbits = DATA_W - 1;
      default: dbits = DATA_W;
    endcase
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < dbits) frame[1+i] = data_i[i];
    if (ext_fmt && par_en_i)
      frame[DATA_W+1] = par_odd_i ? ~^data_i : ^data_i;
    len = CNT_W'(dbits + 2 + int'(ext_fmt && par_en_i) + int'(ext_fmt && two_stop_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      line_o <= 1'b1;
    end else if (load_i) begin
      sh_q   <= frame;
      cnt_q  <= len;
      busy_o <= 1'b1;
    end else if (busy_o && tick_i) begin
      if (cnt_q != '0) begin
        line_o <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q  <= cnt_q - 1'b1;
      end else begin
        busy_o <= 1'b0;
        line_o <= 1'b1;
      end
    end
  end

  // R8
  load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
  // R6
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> line_o);
  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= CNT_W'(FRAME_W)));
endmodule

// File: rtl/mdm_tx_front.sv
module mdm_tx_front
  import mdm_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        ctrl_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              rate_stb_i,
  input  logic              ext_clk_i,
  input  logic              rx_clk_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              sync_bit_i,
  output logic              txd_o,
  output logic              active_o
);
  logic [3:0] act_mode;
  logic       tx_en, tick, pump_bit, fr_busy, fr_line, load, sync_q, live;
  logic       unused_ctrl;

  assign tx_en       = ctrl_i[1];
  assign unused_ctrl = ^{ctrl_i[7:6], ctrl_i[0]};

  // adopt a new mode only between characters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_mode <= MD_PDN;
    else if (!fr_busy) act_mode <= ctrl_i[5:2];
  end

  mdm_tx_clk_sel #(.STAGES(SYNC_STAGES)) u_clk_sel (
    .clk_i, .rst_ni,
    .mode_i     (act_mode),
    .rate_stb_i,
    .ext_clk_i,
    .rx_clk_i,
    .sync_bit_i,
    .tick_o     (tick),
    .bit_o      (pump_bit)
  );

  assign ready_o = tx_en && is_async(act_mode) && !fr_busy;
  assign load    = valid_i && ready_o;

  mdm_tx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk_i, .rst_ni,
    .load_i     (load),
    .mode_i     (act_mode),
    .data_i,
    .par_en_i,
    .par_odd_i,
    .two_stop_i,
    .tick_i     (tick),
    .busy_o     (fr_busy),
    .line_o     (fr_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sync_q <= 1'b1;
    else if (!is_sync(act_mode)) sync_q <= 1'b1;
    else if (tick)               sync_q <= pump_bit;
  end

  assign live     = tx_en && (is_sync(act_mode) || is_async(act_mode));
  assign txd_o    = !live ? 1'b1 : (is_sync(act_mode) ? sync_q : fr_line);
  assign active_o = tx_en && (is_sync(act_mode) || fr_busy);

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fr_busy) |-> $stable(act_mode));
  // R2
  pd_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_async(act_mode) |-> !load);
endmodule

// File: tb/mdm_tx_front_bench.sv
module mdm_tx_front_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic       par_en = 0, par_odd = 0, two_stop = 0, stb = 0;
  logic       ext_clk = 0, rx_clk = 0, valid = 0, sync_bit = 1;
  logic [7:0] data = 8'h00;
  logic       ready, txd, active;
  int         tests = 0, fails = 0, div = 0;
  bit         done = 0;

  mdm_tx_front u_mdm_tx_front (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .par_en_i(par_en),
    .par_odd_i(par_odd), .two_stop_i(two_stop), .rate_stb_i(stb),
    .ext_clk_i(ext_clk), .rx_clk_i(rx_clk), .data_i(data), .valid_i(valid),
    .ready_o(ready), .sync_bit_i(sync_bit), .txd_o(txd), .active_o(active)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    div = (div + 1) % 8;
    stb = (div == 0);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!stb);
  endtask

  function automatic int exp_len(logic [3:0] m, logic pe, logic two);
    case (m)
      4'd4: return 8;
      4'd5: return 9;
      4'd6: return 10;
      default: return 10 + int'(pe) + int'(two);
    endcase
  endfunction

  function automatic logic [11:0] exp_bits(logic [3:0] m, logic [7:0] d, logic pe, logic od);
    logic p = od ? ~^d : ^d;
    case (m)
      4'd4: return {5'h1F, d[5:0], 1'b0};
      4'd5: return {4'hF, d[6:0], 1'b0};
      4'd6: return {3'h7, d, 1'b0};
      default: return pe ? {2'b11, p, d, 1'b0} : {3'h7, d, 1'b0};
    endcase
  endfunction

  function automatic logic [7:0] mk_ctrl(logic [3:0] m, logic en);
    return {2'b00, m, en, 1'b0};
  endfunction

  task automatic set_mode(logic [3:0] m, logic en);
    @(negedge clk); ctrl = mk_ctrl(m, en);
    repeat (2) @(negedge clk);
  endtask

  // sw < 0 means no mode switch during the frame
  task automatic send_char(logic [3:0] m, logic [7:0] d, logic pe, logic od,
                           logic two, int sw, logic [3:0] m2);
    int n = exp_len(m, pe, two);
    logic [11:0] eb = exp_bits(m, d, pe, od);
    int guard = 0;
    set_mode(m, 1'b1);
    par_en = pe; par_odd = od; two_stop = two;
    while (!ready && guard < 200) begin @(negedge clk); guard++; end
    chk("R8 ready when idle", ready, 1);
    valid = 1; data = d;
    @(posedge clk);
    @(negedge clk); valid = 0;
    chk("R8 ready low after accept", ready, 0);
    for (int i = 0; i < n; i++) begin
      wait_tick();
      @(negedge clk);
      if (m == 4'd7) chk($sformatf("R7 bit %0d", i), txd, eb[i]);
      else if (sw >= 0) chk($sformatf("R9 bit %0d", i), txd, eb[i]);
      else chk($sformatf("R6 bit %0d", i), txd, eb[i]);
      if (i == sw) ctrl = mk_ctrl(m2, 1'b1);
    end
    wait_tick();
    @(negedge clk);
    chk("R8 ready after last stop", ready, 1);
    chk("R6 idle after frame", txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R10 txd reset", txd, 1);
    chk("R10 ready reset", ready, 0);
    chk("R10 active reset", active, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: power down ignores offered characters
    set_mode(4'd0, 1'b1);
    valid = 1; data = 8'h00;
    repeat (20) @(negedge clk);
    chk("R2 ready pd", ready, 0);
    chk("R2 txd pd", txd, 1);
    chk("R2 active pd", active, 0);
    valid = 0;
    set_mode(4'd6, 1'b1);
    for (int k = 0; k < 3; k++) begin
      wait_tick(); @(negedge clk);
      chk("R2 nothing sent after pd", txd, 1);
    end
    set_mode(4'd10, 1'b1);
    chk("R2 reserved ready", ready, 0);
    chk("R2 reserved txd", txd, 1);
    chk("R2 reserved active", active, 0);

    // R1: enable low
    set_mode(4'd6, 1'b0);
    chk("R1 ready off", ready, 0);
    chk("R1 active off", active, 0);
    set_mode(4'd1, 1'b0);
    sync_bit = 0;
    for (int k = 0; k < 3; k++) begin
      wait_tick(); @(negedge clk);
      chk("R1 txd off", txd, 1);
    end
    chk("R1 active off sync", active, 0);

    // R3: internal synchronous
    set_mode(4'd1, 1'b1);
    for (int k = 0; k < 10; k++) begin
      logic b = 1'($urandom);
      @(negedge clk); sync_bit = b;
      wait_tick(); @(negedge clk);
      chk("R3 int sync bit", txd, b);
    end
    chk("R3 active", active, 1);

    // R4: external synchronous, receive clock ignored
    set_mode(4'd2, 1'b1);
    for (int k = 0; k < 8; k++) begin
      logic b = 1'($urandom);
      @(negedge clk); sync_bit = b;
      @(negedge clk); ext_clk = 1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R4 ext sync bit", txd, b);
      ext_clk = 0; sync_bit = ~b;
      repeat (2) @(negedge clk); rx_clk = 1;
      repeat (5) @(negedge clk);
      chk("R4 rx edge ignored", txd, b);
      rx_clk = 0;
      repeat (2) @(negedge clk);
    end

    // R5: slave synchronous, external clock ignored
    set_mode(4'd3, 1'b1);
    for (int k = 0; k < 8; k++) begin
      logic b = 1'($urandom);
      @(negedge clk); sync_bit = b;
      @(negedge clk); rx_clk = 1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R5 slave sync bit", txd, b);
      rx_clk = 0; sync_bit = ~b;
      repeat (2) @(negedge clk); ext_clk = 1;
      repeat (5) @(negedge clk);
      chk("R5 ext edge ignored", txd, b);
      ext_clk = 0;
      repeat (2) @(negedge clk);
    end

    // R6 / R7 directed corners
    send_char(4'd4, 8'hC1, 0, 0, 0, -1, 4'd0);
    send_char(4'd5, 8'hA5, 0, 0, 0, -1, 4'd0);
    send_char(4'd6, 8'h80, 0, 0, 0, -1, 4'd0);
    send_char(4'd7, 8'h03, 1, 0, 1, -1, 4'd0);
    send_char(4'd7, 8'h03, 1, 1, 0, -1, 4'd0);
    send_char(4'd7, 8'hFF, 0, 0, 1, -1, 4'd0);

    // R9: switch to 10-bit format in mid-frame of an 8-bit character
    send_char(4'd4, 8'h3C, 0, 0, 0, 2, 4'd6);
    send_char(4'd6, 8'h5A, 0, 0, 0, -1, 4'd0);

    // random characters in random formats
    for (int k = 0; k < 20; k++) begin
      logic [3:0] m = 4'(4 + ($urandom % 4));
      send_char(m, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), -1, 4'd0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule